// File: doc/BRIEF.md
# Oversampled RZ Clock and Data Recovery

This block pulls a bit clock and retimed NRZ data out of the positive and negative return-to-zero pulse streams that a line receiver's slicers produce. Each channel runs a digital phase tracker from a reference clock at sixteen times the line rate: 24.704 MHz for a 1.544 Mb/s line, 32.768 MHz for a 2.048 Mb/s line. A 4-bit phase counter wraps once per bit period. The rising edge of each incoming pulse is compared with the counter, and the counter is pulled one step toward the point where pulses start at phase zero. This lets the loop follow input jitter and small rate offsets. When a long run of zeros brings no pulses, the counter keeps running freely, so the recovered clock never stops.

Each channel also has a bypass mode. It is selected by a per-channel bit, or for all channels at once by a global force input. In bypass the raw slicer bits go straight to the data outputs, and the clock output carries their exclusive-OR, for use by clock recovery outside the block. Clearing the per-channel bit (its reset value) selects recovery mode. The force input wins over every per-channel bit.

Top module: `rz_clock_recovery`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released, every channel in recovery mode drives its retimed data low and its clock high. The phase counter starts at 0.
- R2: When no pulse edge arrives, the phase counter advances by one each reference cycle and wraps modulo 16. The recovered clock then repeats every 16 cycles.
- R3: In recovery mode the clock output is high while the phase is 0 to 7 and low while it is 8 to 15.
- R4: A pulse edge is a reference cycle in which (pos OR neg) is 1 after being 0 in the previous cycle. The action depends on the phase at that cycle. At phase 2 to 8 the counter holds for one cycle. At phase 9 to 14 it advances by two. At phase 15, 0 or 1 it advances by one as usual.
- R5: At the cycle where the phase is 8, each rail's retimed output is loaded with 1 if that rail rose (0 to 1) at any cycle since the previous phase-8 load, including this one, and with 0 otherwise. Between loads it holds. The new value is visible from the next cycle.
- R6: When a channel's bypass bit is 1, its positive and negative outputs equal its raw positive and negative inputs in the same cycle. Its clock output equals pos XOR neg.
- R7: When force_bypass is 1, every channel behaves as in R6 whatever its bypass bit is.
- R8: Bypassing one channel has no effect on the outputs of any other channel in recovery mode.
- R9: With bit periods jittered between 14 and 18 reference cycles and pulse widths of 4 to 12 cycles, each pulse is reported in exactly one bit, as R5 defines. A pulse still high across a phase-8 load is not counted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, 16 times the line rate |
| rst_n | input | 1 | Active-low synchronous reset |
| force_bypass | input | 1 | Puts every channel in bypass when high |
| chan_bypass | input | NCH | Per-channel bypass select, 1 = bypass |
| pos_pulse | input | NCH | Positive slicer RZ bit per channel |
| neg_pulse | input | NCH | Negative slicer RZ bit per channel |
| rec_clk | output | NCH | Recovered clock, or pos XOR neg in bypass |
| rec_pos | output | NCH | Retimed positive rail, or raw positive in bypass |
| rec_neg | output | NCH | Retimed negative rail, or raw negative in bypass |

## Verification
The bench builds the block with OSR = 16 and NCH = 2. Two channels are enough to bypass one while the other keeps recovering, and to show that the force input overrides a channel whose own bit is clear. The 16-step phase puts both correction windows and the free-running wrap within a few hundred cycles. Jittered bit periods of 14 to 18 cycles with random pulse widths exercise every correction window, as well as pulses still high when the phase-8 load happens.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  typedef enum logic {
    MODE_RECOVER = 1'b0,
    MODE_BYPASS  = 1'b1
  } chan_mode_e;

  // Next phase step: late edges (2..half) hold, early edges (half+1..osr-2)
  // skip one, edges near zero leave the normal increment alone.
  function automatic int unsigned next_phase(input int unsigned ph,
                                             input logic        edge_seen,
                                             input int unsigned osr);
    int unsigned half;
    half = osr / 2;
    if (!edge_seen)                    return (ph + 1) % osr;
    if (ph >= 2 && ph <= half)         return ph;
    if (ph > half && ph <= osr - 2)    return (ph + 2) % osr;
    return (ph + 1) % osr;
  endfunction

  function automatic logic clk_level(input int unsigned ph,
                                     input int unsigned osr);
    return (ph < osr / 2);
  endfunction

endpackage

// File: rtl/cdr_phase_track.sv
module cdr_phase_track
  import cdr_pkg::*;
#(
  parameter  int unsigned OSR  = 16,
  localparam int unsigned PH_W = $clog2(OSR)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_in,
  input  logic neg_in,
  output logic sample_now,
  output logic rec_clk
);

  localparam int unsigned HALF = OSR / 2;

  logic [PH_W-1:0] phase_q;
  logic            mark;
  logic            mark_d;
  logic            pulse_edge;

  assign mark       = pos_in | neg_in;
  assign pulse_edge = mark & ~mark_d;
  assign sample_now = (phase_q == PH_W'(HALF));
  assign rec_clk    = clk_level(32'(phase_q), OSR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      mark_d  <= 1'b0;
    end else begin
      phase_q <= PH_W'(next_phase(32'(phase_q), pulse_edge, OSR));
      mark_d  <= mark;
    end
  end

  // R2: without an edge the counter steps by one
  p_freerun_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_edge |=> phase_q == $past(phase_q) + PH_W'(1));

  // R4: late edge holds the counter
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_edge && 32'(phase_q) >= 2 && 32'(phase_q) <= HALF)
      |=> phase_q == $past(phase_q));

  // R4: early edge advances by two
  p_skip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_edge && 32'(phase_q) > HALF && 32'(phase_q) <= OSR - 2)
      |=> phase_q == $past(phase_q) + PH_W'(2));

  // R3: clock falls exactly at the sample phase and rises at phase zero
  p_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rec_clk) |-> sample_now);
  p_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_clk) |-> phase_q == '0);

endmodule

// File: rtl/cdr_retimer.sv
module cdr_retimer (
  input  logic clk,
  input  logic rst_n,
  input  logic rail_in,
  input  logic sample_now,
  output logic rail_q
);

  logic rail_d;
  logic seen;
  logic rise;

  assign rise = rail_in & ~rail_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rail_d <= 1'b0;
      seen   <= 1'b0;
      rail_q <= 1'b0;
    end else begin
      rail_d <= rail_in;
      if (sample_now) begin
        rail_q <= seen | rise;
        seen   <= 1'b0;
      end else begin
        seen   <= seen | rise;
      end
    end
  end

  // R5: retimed data moves only after a sample point
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_now |=> $stable(rail_q));

  // R5: a rise at the sample point is reported
  p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_now && rise) |=> rail_q);

endmodule

// File: rtl/cdr_out_sel.sv
module cdr_out_sel
  import cdr_pkg::*;
(
  input  chan_mode_e mode,
  input  logic       raw_pos,
  input  logic       raw_neg,
  input  logic       rec_clk,
  input  logic       rec_pos,
  input  logic       rec_neg,
  output logic       clk_o,
  output logic       pos_o,
  output logic       neg_o
);

  always_comb begin
    if (mode == MODE_BYPASS) begin
      clk_o = raw_pos ^ raw_neg;
      pos_o = raw_pos;
      neg_o = raw_neg;
    end else begin
      clk_o = rec_clk;
      pos_o = rec_pos;
      neg_o = rec_neg;
    end
  end

endmodule

// File: rtl/cdr_channel.sv
module cdr_channel
  import cdr_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  chan_mode_e mode,
  input  logic       pos_in,
  input  logic       neg_in,
  output logic       clk_o,
  output logic       pos_o,
  output logic       neg_o
);

  localparam int unsigned RAILS = 2;

  logic             sample_now;
  logic             rec_clk;
  logic [RAILS-1:0] rail_raw;
  logic [RAILS-1:0] rail_rt;

  assign rail_raw = {neg_in, pos_in};

  cdr_phase_track #(.OSR(OSR)) track_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos_in     (pos_in),
    .neg_in     (neg_in),
    .sample_now (sample_now),
    .rec_clk    (rec_clk)
  );

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    cdr_retimer rt_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rail_in    (rail_raw[r]),
      .sample_now (sample_now),
      .rail_q     (rail_rt[r])
    );
  end

  cdr_out_sel sel_i (
    .mode    (mode),
    .raw_pos (pos_in),
    .raw_neg (neg_in),
    .rec_clk (rec_clk),
    .rec_pos (rail_rt[0]),
    .rec_neg (rail_rt[1]),
    .clk_o   (clk_o),
    .pos_o   (pos_o),
    .neg_o   (neg_o)
  );

  // R6: bypassed channel shows raw rails and their XOR
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BYPASS) |-> (pos_o == pos_in && neg_o == neg_in
                               && clk_o == (pos_in ^ neg_in)));

  // R3: recovering channel forwards the tracker clock
  p_recclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RECOVER) |-> clk_o == rec_clk);

endmodule

// File: rtl/rz_clock_recovery.sv
module rz_clock_recovery
  import cdr_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned NCH = 2
) (
  input  logic           clk_ref,
  input  logic           rst_n,
  input  logic           force_bypass,
  input  logic [NCH-1:0] chan_bypass,
  input  logic [NCH-1:0] pos_pulse,
  input  logic [NCH-1:0] neg_pulse,
  output logic [NCH-1:0] rec_clk,
  output logic [NCH-1:0] rec_pos,
  output logic [NCH-1:0] rec_neg
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_mode_e mode;

    assign mode = (force_bypass || chan_bypass[c]) ? MODE_BYPASS : MODE_RECOVER;

    cdr_channel #(.OSR(OSR)) ch_i (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .mode   (mode),
      .pos_in (pos_pulse[c]),
      .neg_in (neg_pulse[c]),
      .clk_o  (rec_clk[c]),
      .pos_o  (rec_pos[c]),
      .neg_o  (rec_neg[c])
    );

    // R7: global force wins over the channel bit
    p_force_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      force_bypass |-> (rec_pos[c] == pos_pulse[c] && rec_neg[c] == neg_pulse[c]
                        && rec_clk[c] == (pos_pulse[c] ^ neg_pulse[c])));
  end

endmodule

// File: tb/rz_clock_recovery_tb_top.sv
`timescale 1ns/1ps
module rz_clock_recovery_tb_top;

  localparam int OSR = 16;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           force_bypass = 1'b0;
  logic [NCH-1:0] chan_bypass = '0;
  logic [NCH-1:0] pos_pulse = '0;
  logic [NCH-1:0] neg_pulse = '0;
  wire  [NCH-1:0] rec_clk;
  wire  [NCH-1:0] rec_pos;
  wire  [NCH-1:0] rec_neg;

  always #2.5 clk = ~clk;

  rz_clock_recovery #(.OSR(OSR), .NCH(NCH)) dut_i (
    .clk_ref      (clk),
    .rst_n        (rst_n),
    .force_bypass (force_bypass),
    .chan_bypass  (chan_bypass),
    .pos_pulse    (pos_pulse),
    .neg_pulse    (neg_pulse),
    .rec_clk      (rec_clk),
    .rec_pos      (rec_pos),
    .rec_neg      (rec_neg)
  );

  int compared = 0;
  int mismatched = 0;

  // reference model state
  int m_ph [NCH];
  bit m_mark_d [NCH];
  bit m_pd [NCH], m_nd [NCH];
  bit m_sp [NCH], m_sn [NCH];
  bit m_dp [NCH], m_dn [NCH];

  // stimulus generator state
  int g_left [NCH];
  int g_hi [NCH];
  bit g_pol [NCH];
  int jit = 0;
  int ones_pct = 0;
  int wmin = 8;
  int wmax = 8;

  string tag_clk = "R3";
  string tag_dat = "R5";

  task automatic check1(string req, string what, int ch, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s ch%0d actual=%0b expected=%0b at %0t", req, what, ch, act, exp, $time);
    end
  endtask

  function automatic int phase_delta(int ph, bit edge_seen);
    if (!edge_seen) return 1;
    case (ph)
      2, 3, 4, 5, 6, 7, 8:        return 0;
      9, 10, 11, 12, 13, 14:      return 2;
      default:                    return 1;
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_ph[c] = 0; m_mark_d[c] = 0; m_pd[c] = 0; m_nd[c] = 0;
      m_sp[c] = 0; m_sn[c] = 0; m_dp[c] = 0; m_dn[c] = 0;
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < NCH; c++) begin
      bit p, n, edge_seen, pr, nr;
      p = pos_pulse[c];
      n = neg_pulse[c];
      edge_seen = (p || n) && !m_mark_d[c];
      pr = p && !m_pd[c];
      nr = n && !m_nd[c];
      if (m_ph[c] == 8) begin
        m_dp[c] = m_sp[c] || pr;
        m_dn[c] = m_sn[c] || nr;
        m_sp[c] = 0;
        m_sn[c] = 0;
      end else begin
        m_sp[c] = m_sp[c] || pr;
        m_sn[c] = m_sn[c] || nr;
      end
      m_ph[c] = (m_ph[c] + phase_delta(m_ph[c], edge_seen)) & 15;
      m_mark_d[c] = p || n;
      m_pd[c] = p;
      m_nd[c] = n;
    end
  endtask

  task automatic check_all();
    for (int c = 0; c < NCH; c++) begin
      bit byp, others;
      byp = force_bypass || chan_bypass[c];
      others = 0;
      for (int o = 0; o < NCH; o++) if (o != c && chan_bypass[o]) others = 1;
      if (force_bypass) begin
        check1("R7", "clk", c, rec_clk[c], pos_pulse[c] ^ neg_pulse[c]);
        check1("R7", "pos", c, rec_pos[c], pos_pulse[c]);
        check1("R7", "neg", c, rec_neg[c], neg_pulse[c]);
      end else if (byp) begin
        check1("R6", "clk", c, rec_clk[c], pos_pulse[c] ^ neg_pulse[c]);
        check1("R6", "pos", c, rec_pos[c], pos_pulse[c]);
        check1("R6", "neg", c, rec_neg[c], neg_pulse[c]);
      end else if (others) begin
        check1("R8", "clk", c, rec_clk[c], (m_ph[c] / (OSR / 2)) == 0);
        check1("R8", "pos", c, rec_pos[c], m_dp[c]);
        check1("R8", "neg", c, rec_neg[c], m_dn[c]);
      end else begin
        check1(tag_clk, "clk", c, rec_clk[c], (m_ph[c] / (OSR / 2)) == 0);
        check1(tag_dat, "pos", c, rec_pos[c], m_dp[c]);
        check1(tag_dat, "neg", c, rec_neg[c], m_dn[c]);
      end
    end
  endtask

  task automatic gen_drive();
    for (int c = 0; c < NCH; c++) begin
      if (g_left[c] <= 0) begin
        bit one;
        g_left[c] = 16 + ((jit > 0) ? (int'($urandom_range(0, 2 * jit)) - jit) : 0);
        one = (int'($urandom % 100) < ones_pct);
        g_hi[c] = one ? int'($urandom_range(wmin, wmax)) : 0;
        if (one) g_pol[c] = !g_pol[c];
      end
      pos_pulse[c] = (g_hi[c] > 0) && g_pol[c];
      neg_pulse[c] = (g_hi[c] > 0) && !g_pol[c];
      if (g_hi[c] > 0) g_hi[c]--;
      g_left[c]--;
    end
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      check_all();
      gen_drive();
      model_step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    for (int c = 0; c < NCH; c++) begin
      g_left[c] = 0; g_hi[c] = 0; g_pol[c] = 0;
    end
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      check1("R1", "clk", c, rec_clk[c], 1'b1);
      check1("R1", "pos", c, rec_pos[c], 1'b0);
      check1("R1", "neg", c, rec_neg[c], 1'b0);
    end
    rst_n = 1'b1;
    model_step();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      check1("R1", "clk", c, rec_clk[c], 1'b1);
      check1("R1", "pos", c, rec_pos[c], 1'b0);
    end
    gen_drive();
    model_step();

    // R2: no pulses, clock free-runs
    tag_clk = "R2"; ones_pct = 0;
    run(48);

    // R4 / R5: steady all-ones, channels offset from the counter
    tag_clk = "R4"; tag_dat = "R5";
    ones_pct = 100; wmin = 8; wmax = 8; jit = 0;
    g_left[0] = 5; g_left[1] = 11;
    run(60 * 16);

    // R9: jittered periods and random widths
    tag_dat = "R9"; jit = 2; ones_pct = 50; wmin = 4; wmax = 12;
    run(300 * 16);

    // R6 / R8: one channel bypassed at a time
    tag_dat = "R5";
    chan_bypass = 2'b01;
    run(150 * 16);
    chan_bypass = 2'b10;
    run(100 * 16);

    // R7: force overrides clear channel bits
    chan_bypass = 2'b01; force_bypass = 1'b1;
    run(100 * 16);
    force_bypass = 1'b0; chan_bypass = 2'b00;
    tag_clk = "R3";
    run(80 * 16);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule